// File: doc/BRIEF.md
# Embedded-Sync Reference Decoder

This block watches a clocked video sample stream that carries its timing inside the data. A qualifier marks which cycles carry a real sample. The block looks for the four-word timing reference: an all-ones word, two all-zero words, then a sync word. It decodes the horizontal-blanking, vertical-blanking and field bits of that sync word and keeps them as the current line state until the next reference arrives.

Each accepted sample produces a registered output beat that carries several flags:
- whether the sample is active picture;
- the current H, V and F states;
- a start-of-line pulse and a start-of-frame pulse;
- a flag for luma samples inside vertical blanking, which a downstream ancillary-data capture stage can use.

Two parameters set the block up. One selects an 8-bit or a 10-bit bus. In 10-bit mode the two low bits of every reference word are ignored, so a source that only drives eight bits still locks. The other selects whether luma is multiplexed with chroma on one bus or carried on a bus of its own.

Top module: `trs_sync_decoder`

## Requirements
- R1: A timing reference is recognised only as four accepted samples in a row: all-ones, zero, zero, then the sync word. In 10-bit mode bits [1:0] of all four words are ignored (0x3FC, 0x003, 0x002 form a valid opening). In 8-bit mode all eight bits are compared, so 0xFC is not an all-ones word.
- R2: The sync word is decoded with H at bit 6, V at bit 7 and F at bit 8 in 10-bit mode, and with H at bit 4, V at bit 5 and F at bit 6 in 8-bit mode. No other bit has any effect.
- R3: o_h, o_v and o_f take the decoded values on the output beat of the sync-word sample, one clock after that sample is accepted. They then hold until the next complete reference.
- R4: When a non-matching word breaks a partial reference, the search starts again. If the breaking word is all-ones, it counts as the first word of a new reference.
- R5: A cycle with i_valid low neither advances nor clears the reference search. On the next clock it gives o_valid, o_active, o_sol, o_sof and o_anc_y all low.
- R6: o_active is high on the output beat of each accepted sample that follows a reference with H=0 and V=0 and is not itself part of a reference. It stays low from any reference with H=1 or V=1 until the next reference with H=0 and V=0.
- R7: o_sol pulses together with o_active on the first active sample after each reference with H=0 and V=0, and on no other beat.
- R8: o_sof pulses together with o_sol on the first active sample after V has changed from 1 to 0 with F=0. It does not pulse when that change comes with F=1.
- R9: o_anc_y is high for luma samples that arrive while V=1 and H=0, excluding reference words. In multiplexed mode, luma is the second, fourth, sixth and later accepted samples after the sync word. With a separate luma bus, every sample is luma.
- R10: After reset and until the first complete reference, the block reports H=1, V=1, F=0 and never raises o_active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | High when i_data carries a sample |
| i_data | input | WIDTH_BITS | Video sample word |
| o_valid | output | 1 | Output beat for the sample accepted on the previous edge |
| o_active | output | 1 | That sample is active picture |
| o_h | output | 1 | Current horizontal-blanking state |
| o_v | output | 1 | Current vertical-blanking state |
| o_f | output | 1 | Current field (1 = field 1) |
| o_sol | output | 1 | First active sample of a line |
| o_sof | output | 1 | First active sample of a frame |
| o_anc_y | output | 1 | Luma sample inside vertical blanking |

## Verification
On every cycle, the assertions check the following:
- active picture never coincides with reported blanking;
- line and frame pulses only ride on active samples, and a frame pulse never appears in field 1;
- the ancillary flag stays inside vertical blanking and outside horizontal blanking;
- an idle cycle leaves the search state and the line state untouched and produces a quiet output beat.

Only the bench's scenarios can show the rest: that the exact reference sequence is recognised, in both widths and with or without noise in the low bits; that broken references restart correctly; that the luma phase after each sync word is right; and that a frame pulse follows a field-0 vertical-blanking exit but not a field-1 one.

// File: rtl/trs_pkg.sv
package trs_pkg;

    // Words are normalised to this width, MSB-aligned, before matching.
    localparam int NORM_W   = 10;
    localparam int CMP_LSB  = 2;
    localparam int H_POS    = 6;
    localparam int V_POS    = 7;
    localparam int F_POS    = 8;

    typedef enum logic [1:0] {
        SEEK_IDLE  = 2'd0,
        SEEK_ONES  = 2'd1,
        SEEK_ZERO1 = 2'd2,
        SEEK_ZERO2 = 2'd3
    } seek_state_t;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } line_state_t;

    localparam line_state_t BLANK_STATE = '{f: 1'b0, v: 1'b1, h: 1'b1};

    function automatic logic word_is_ones(input logic [NORM_W-1:0] w);
        return &w[NORM_W-1:CMP_LSB];
    endfunction

    function automatic logic word_is_zero(input logic [NORM_W-1:0] w);
        return ~|w[NORM_W-1:CMP_LSB];
    endfunction

    function automatic line_state_t decode_sync(input logic [NORM_W-1:0] w);
        line_state_t s;
        s.f = w[F_POS];
        s.v = w[V_POS];
        s.h = w[H_POS];
        return s;
    endfunction

endpackage

// File: rtl/trs_matcher.sv
module trs_matcher
    import trs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              i_valid,
    input  logic [NORM_W-1:0] i_word,
    output logic              o_hit,
    output line_state_t       o_sync,
    output logic              o_in_ref
);

    seek_state_t state_q;
    seek_state_t state_d;
    logic        ones_w;
    logic        zero_w;

    assign ones_w = word_is_ones(i_word);
    assign zero_w = word_is_zero(i_word);

    always_comb begin
        state_d = state_q;
        o_hit   = 1'b0;
        if (i_valid) begin
            case (state_q)
                SEEK_IDLE:  state_d = ones_w ? SEEK_ONES : SEEK_IDLE;
                SEEK_ONES:  state_d = zero_w ? SEEK_ZERO1 :
                                      (ones_w ? SEEK_ONES : SEEK_IDLE);
                SEEK_ZERO1: state_d = zero_w ? SEEK_ZERO2 :
                                      (ones_w ? SEEK_ONES : SEEK_IDLE);
                SEEK_ZERO2: begin
                    o_hit   = 1'b1;
                    state_d = SEEK_IDLE;
                end
                default:    state_d = SEEK_IDLE;
            endcase
        end
    end

    assign o_sync   = decode_sync(i_word);
    assign o_in_ref = (state_q != SEEK_IDLE) || ones_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEEK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    AST_SEEK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !i_valid |=> $stable(state_q));                                   // R5

    AST_ONES_RESTART: assert property (@(posedge clk) disable iff (rst)
        (i_valid && state_q != SEEK_ZERO2 && ones_w) |=> state_q == SEEK_ONES); // R4

    AST_HIT_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (i_valid && o_hit) |=> state_q == SEEK_IDLE);                     // R1

endmodule

// File: rtl/trs_tracker.sv
module trs_tracker
    import trs_pkg::*;
#(
    parameter bit YC_MUX = 1'b1
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        i_valid,
    input  logic        i_hit,
    input  line_state_t i_sync,
    input  logic        i_in_ref,
    output logic        o_valid,
    output logic        o_active,
    output logic        o_h,
    output logic        o_v,
    output logic        o_f,
    output logic        o_sol,
    output logic        o_sof,
    output logic        o_anc_y
);

    line_state_t cur_q;
    logic        sol_arm_q;
    logic        sof_arm_q;
    logic        y_phase_q;
    logic        take_ref;
    logic        act_smp;
    logic        luma_smp;
    logic        anc_smp;

    assign take_ref = i_valid && i_hit;
    assign act_smp  = i_valid && !i_in_ref && !cur_q.h && !cur_q.v;

    generate
        if (YC_MUX) begin : g_muxed_luma
            assign luma_smp = y_phase_q;
        end else begin : g_own_luma
            assign luma_smp = 1'b1;
        end
    endgenerate

    assign anc_smp = i_valid && !i_in_ref && cur_q.v && !cur_q.h && luma_smp;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= BLANK_STATE;
            sol_arm_q <= 1'b0;
            sof_arm_q <= 1'b0;
            y_phase_q <= 1'b0;
            o_valid   <= 1'b0;
            o_active  <= 1'b0;
            o_sol     <= 1'b0;
            o_sof     <= 1'b0;
            o_anc_y   <= 1'b0;
        end else begin
            o_valid  <= i_valid;
            o_active <= act_smp;
            o_sol    <= act_smp && sol_arm_q;
            o_sof    <= act_smp && sof_arm_q;
            o_anc_y  <= anc_smp;
            if (take_ref) begin
                cur_q     <= i_sync;
                y_phase_q <= 1'b0;
                sol_arm_q <= !i_sync.h && !i_sync.v;
                if (cur_q.v && !i_sync.v && !i_sync.f) begin
                    sof_arm_q <= 1'b1;
                end else if (i_sync.v) begin
                    sof_arm_q <= 1'b0;
                end
            end else begin
                if (i_valid) begin
                    y_phase_q <= ~y_phase_q;
                end
                if (act_smp) begin
                    sol_arm_q <= 1'b0;
                    sof_arm_q <= 1'b0;
                end
            end
        end
    end

    assign o_h = cur_q.h;
    assign o_v = cur_q.v;
    assign o_f = cur_q.f;

    AST_ACTIVE_OPEN: assert property (@(posedge clk) disable iff (rst)
        o_active |-> (!o_h && !o_v));                                     // R6

    AST_SOL_ON_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        o_sol |-> o_active);                                              // R7

    AST_SOF_FIELD0: assert property (@(posedge clk) disable iff (rst)
        o_sof |-> (o_sol && !o_f));                                       // R8

    AST_ANC_IN_VBLANK: assert property (@(posedge clk) disable iff (rst)
        o_anc_y |-> (o_v && !o_h && !o_active));                          // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !i_valid |=> (!o_valid && !o_active && !o_anc_y && !o_sol));      // R5

    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !take_ref |=> $stable(cur_q));                                    // R3

endmodule

// File: rtl/trs_sync_decoder.sv
module trs_sync_decoder
    import trs_pkg::*;
#(
    parameter int WIDTH_BITS = 10,
    parameter bit YC_MUX     = 1'b1
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  i_valid,
    input  logic [WIDTH_BITS-1:0] i_data,
    output logic                  o_valid,
    output logic                  o_active,
    output logic                  o_h,
    output logic                  o_v,
    output logic                  o_f,
    output logic                  o_sol,
    output logic                  o_sof,
    output logic                  o_anc_y
);

    localparam int PAD_W = NORM_W - WIDTH_BITS;

    logic [NORM_W-1:0] norm_word;
    logic              hit;
    line_state_t       sync;
    logic              in_ref;

    generate
        if (PAD_W == 0) begin : g_wide_bus
            assign norm_word = i_data;
        end else begin : g_narrow_bus
            assign norm_word = {i_data, {PAD_W{1'b0}}};
        end
    endgenerate

    trs_matcher u_matcher (
        .clk      (clk),
        .rst      (rst),
        .i_valid  (i_valid),
        .i_word   (norm_word),
        .o_hit    (hit),
        .o_sync   (sync),
        .o_in_ref (in_ref)
    );

    trs_tracker #(
        .YC_MUX (YC_MUX)
    ) u_tracker (
        .clk      (clk),
        .rst      (rst),
        .i_valid  (i_valid),
        .i_hit    (hit),
        .i_sync   (sync),
        .i_in_ref (in_ref),
        .o_valid  (o_valid),
        .o_active (o_active),
        .o_h      (o_h),
        .o_v      (o_v),
        .o_f      (o_f),
        .o_sol    (o_sol),
        .o_sof    (o_sof),
        .o_anc_y  (o_anc_y)
    );

endmodule

// File: tb/trs_sync_decoder_tb.sv
module trs_sync_decoder_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vld = 1'b0;
    logic [9:0] d10 = '0;
    logic       vld8 = 1'b0;
    logic [7:0] d8 = '0;

    logic o_valid, o_active, o_h, o_v, o_f, o_sol, o_sof, o_anc_y;
    logic p_valid, p_active, p_h, p_v, p_f, p_sol, p_sof, p_anc_y;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    trs_sync_decoder #(.WIDTH_BITS(10), .YC_MUX(1'b1)) u_dut (
        .clk(clk), .rst(rst), .i_valid(vld), .i_data(d10),
        .o_valid(o_valid), .o_active(o_active), .o_h(o_h), .o_v(o_v),
        .o_f(o_f), .o_sol(o_sol), .o_sof(o_sof), .o_anc_y(o_anc_y));

    trs_sync_decoder #(.WIDTH_BITS(8), .YC_MUX(1'b0)) u_dut8 (
        .clk(clk), .rst(rst), .i_valid(vld8), .i_data(d8),
        .o_valid(p_valid), .o_active(p_active), .o_h(p_h), .o_v(p_v),
        .o_f(p_f), .o_sol(p_sol), .o_sof(p_sof), .o_anc_y(p_anc_y));

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic push(input logic [9:0] w);
        @(negedge clk);
        vld = 1'b1;
        d10 = w;
        @(posedge clk);
        #1;
        vld = 1'b0;
    endtask

    task automatic push8(input logic [7:0] w);
        @(negedge clk);
        vld8 = 1'b1;
        d8 = w;
        @(posedge clk);
        #1;
        vld8 = 1'b0;
    endtask

    task automatic gap();
        @(negedge clk);
        vld = 1'b0;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [9:0] xyz(input logic f, input logic v, input logic h);
        return 10'h200 | ({7'd0, f, v, h} << 6);
    endfunction

    task automatic send_ref(input logic f, input logic v, input logic h);
        push(10'h3FF);
        push(10'h000);
        push(10'h000);
        push(xyz(f, v, h));
        chk("R3 f", o_f, f);
        chk("R3 v", o_v, v);
        chk("R3 h", o_h, h);
    endtask

    task automatic t_reset();
        chk("R10 h", o_h, 1'b1);
        chk("R10 v", o_v, 1'b1);
        chk("R10 f", o_f, 1'b0);
        chk("R5 valid", o_valid, 1'b0);
        push(10'h200);
        chk("R10 active before lock", o_active, 1'b0);
        chk("R10 h before lock", o_h, 1'b1);
    endtask

    task automatic t_first_line();
        send_ref(1'b0, 1'b0, 1'b0);
        chk("R6 sync word not active", o_active, 1'b0);
        push(10'h040);
        chk("R6 active", o_active, 1'b1);
        chk("R7 sol", o_sol, 1'b1);
        chk("R8 sof", o_sof, 1'b1);
        push(10'h1A0);
        chk("R6 active 2nd", o_active, 1'b1);
        chk("R7 sol once", o_sol, 1'b0);
        chk("R8 sof once", o_sof, 1'b0);
        push(10'h3FF);
        chk("R6 ref word not active", o_active, 1'b0);
        push(10'h000);
        push(10'h000);
        push(xyz(1'b0, 1'b0, 1'b1));
        chk("R3 h set", o_h, 1'b1);
        push(10'h080);
        chk("R6 hblank inactive", o_active, 1'b0);
    endtask

    task automatic t_second_line();
        send_ref(1'b0, 1'b0, 1'b0);
        push(10'h123);
        chk("R7 sol new line", o_sol, 1'b1);
        chk("R8 no sof mid frame", o_sof, 1'b0);
        send_ref(1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_split();
        push(10'h3FF);
        gap();
        chk("R5 gap no beat", o_valid, 1'b0);
        push(10'h000);
        gap();
        gap();
        push(10'h000);
        gap();
        push(xyz(1'b0, 1'b1, 1'b1));
        chk("R5 split ref v", o_v, 1'b1);
        chk("R5 split ref h", o_h, 1'b1);
    endtask

    task automatic t_lowbits();
        push(10'h3FC);
        push(10'h003);
        push(10'h002);
        push(xyz(1'b1, 1'b1, 1'b1) | 10'h003);
        chk("R1 low bits ignored f", o_f, 1'b1);
    endtask

    task automatic t_broken();
        push(10'h3FF);
        push(10'h000);
        push(10'h3FF);
        push(10'h000);
        push(10'h000);
        push(xyz(1'b0, 1'b1, 1'b0));
        chk("R4 restart f", o_f, 1'b0);
        chk("R4 restart h", o_h, 1'b0);
        chk("R4 restart v", o_v, 1'b1);
        push(10'h3FF);
        push(10'h000);
        push(10'h100);
        push(10'h000);
        push(10'h3C0);
        chk("R4 broken f unchanged", o_f, 1'b0);
        chk("R4 broken h unchanged", o_h, 1'b0);
    endtask

    task automatic t_vblank();
        send_ref(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) begin
            push(10'h101 + 10'(i));
            chk("R9 luma phase", o_anc_y, (i % 2) == 1);
            chk("R6 vblank inactive", o_active, 1'b0);
        end
        send_ref(1'b0, 1'b1, 1'b1);
        push(10'h101);
        chk("R9 none in hblank", o_anc_y, 1'b0);
        push(10'h102);
        chk("R9 none in hblank 2", o_anc_y, 1'b0);
    endtask

    task automatic t_field1();
        send_ref(1'b1, 1'b0, 1'b0);
        push(10'h150);
        chk("R6 field1 active", o_active, 1'b1);
        chk("R7 field1 sol", o_sol, 1'b1);
        chk("R8 no sof field1", o_sof, 1'b0);
        push(10'h151);
        chk("R7 sol single", o_sol, 1'b0);
    endtask

    task automatic t_frame();
        send_ref(1'b1, 1'b0, 1'b1);
        send_ref(1'b0, 1'b1, 1'b1);
        send_ref(1'b0, 1'b0, 1'b0);
        push(10'h155);
        chk("R8 sof new frame", o_sof, 1'b1);
        chk("R7 sol new frame", o_sol, 1'b1);
        push(10'h156);
        chk("R8 sof single", o_sof, 1'b0);
    endtask

    task automatic t_eight_bit();
        push8(8'hFF); push8(8'h00); push8(8'h00); push8(8'h80);
        chk("R2 8b h clear", p_h, 1'b0);
        chk("R2 8b v clear", p_v, 1'b0);
        push8(8'h44);
        chk("R6 8b active", p_active, 1'b1);
        push8(8'hFF); push8(8'h00); push8(8'h00); push8(8'hE0);
        chk("R2 8b f", p_f, 1'b1);
        chk("R2 8b v", p_v, 1'b1);
        chk("R2 8b h", p_h, 1'b0);
        push8(8'h33);
        chk("R9 own luma bus", p_anc_y, 1'b1);
        push8(8'h34);
        chk("R9 own luma bus 2", p_anc_y, 1'b1);
        push8(8'hFF); push8(8'h00); push8(8'h00); push8(8'h90);
        chk("R2 8b h bit4", p_h, 1'b1);
        chk("R2 8b f clear", p_f, 1'b0);
        push8(8'hFC); push8(8'h00); push8(8'h00); push8(8'h80);
        chk("R1 8b full compare", p_h, 1'b1);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_first_line();
        t_second_line();
        t_split();
        t_lowbits();
        t_broken();
        t_vblank();
        t_field1();
        t_frame();
        t_eight_bit();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            finish_run();
        end
    end

endmodule